// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Pipeline with Selectable Jump Handling

This block is a small instruction pipeline for a toy 16-bit instruction set. It has two stages. The fetch stage drives an address to a synchronous instruction memory. The execute stage decodes and performs the word that comes back one cycle later. The two stages work on neighbouring instructions in the same cycle: while instruction N executes, instruction N+1 is being fetched.

An unconditional control transfer (jump, call or return) changes the fetch address during its execute cycle. The instruction that was fetched in that cycle then sits behind the transfer. A static mode input decides what happens to it. In squash mode the hardware discards it. In delay-slot mode it always executes, so software puts useful work or a no-op there.

A small register file holds the results. It has a combinational inspection port. Each executed instruction is reported once on a retire strobe, together with its address.

Top module: `twostage_pipe`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the fetch address becomes 0, the execute stage becomes empty and all registers become 0. In the first cycle after reset, `imem_addr` is 0 and `retire_valid` is 0.
- R2: The instruction memory returns the word for an address on the clock edge after that address is presented. The execute stage works on the word addressed in the previous cycle. Without a transfer, `imem_addr` rises by one every cycle.
- R3: Instruction word layout: opcode in bits 15:12, destination register in bits 11:8, and an 8-bit immediate in bits 7:0. A jump (opcode 3) loads its immediate as the fetch address, and that target appears on `imem_addr` in the cycle after the jump retires.
- R4: In squash mode (`delay_mode`=0), the instruction fetched behind a jump, call or return never retires and changes no register.
- R5: In delay-slot mode (`delay_mode`=1), the instruction at transfer address + 1 retires in the cycle after the transfer and takes full effect. The transfer target retires in the cycle after that.
- R6: A no-op (opcode 0), and any opcode from 6 to 15, retires but changes no register and does not alter the fetch sequence.
- R7: Load-immediate (opcode 2) writes the immediate to the destination. Add (opcode 1) writes to the destination the 8-bit sum of the registers named in immediate bits 7:4 and 3:0.
- R8: A call (opcode 4) jumps to its immediate and writes a return address into register 15. The return address is the call address + 1 in squash mode and + 2 in delay-slot mode. A return (opcode 5) jumps to the value held in register 15.
- R9: `retire_valid` is high for exactly one cycle per executed instruction, with `retire_pc` equal to that instruction's address.
- R10: Take a sequence that reaches its end through two jumps. If both delay slots are filled with work moved from before the jumps, delay-slot mode reaches the end two cycles earlier than the natural ordering does in squash mode, and leaves the same register results.
- R11: `rf_rdata` shows, in the same cycle, the register selected by `rf_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| delay_mode | input | 1 | Static mode: 0 squashes the instruction behind a transfer, 1 executes it as a delay slot |
| imem_addr | output | 8 | Instruction fetch address |
| imem_rdata | input | 16 | Instruction word, registered by the memory one cycle after its address |
| rf_raddr | input | 4 | Register inspection select |
| rf_rdata | output | 8 | Register inspection data |
| retire_valid | output | 1 | One pulse per executed instruction |
| retire_pc | output | 8 | Address of the retiring instruction |

## Verification
The fetch address and the execute-stage address are both visible at the ports every cycle, through `imem_addr` and `retire_pc`. A wrong program counter, a missing bubble or a squash where none belongs therefore shows up as a mismatch within one or two cycles of the transfer that caused it. A wrong register write shows up on the inspection port. The bench steps the port through every register in turn, so such an error is seen within sixteen cycles, and also in the final register dump. A wrong return address shows up as a wrong retire address right after the return executes. The end-to-end cycle count of each program catches any extra or missing bubble that a local comparison could attribute to the wrong cycle.

// File: rtl/twostage_pkg.sv
// Package: shared encoding and decode for the two-stage pipeline.
// Assumes a fixed 16-bit instruction word and 16 architectural registers.
package twostage_pkg;

    localparam int INSTR_W  = 16;
    localparam int IMM_W    = 8;
    localparam int OPC_W    = 4;
    localparam int RIDX_W   = 4;
    localparam int REG_N    = 1 << RIDX_W;
    localparam int LINK_IDX = REG_N - 1;

    localparam logic [OPC_W-1:0] OPC_NOOP  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'd1;
    localparam logic [OPC_W-1:0] OPC_LOADI = 4'd2;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_CALL  = 4'd4;
    localparam logic [OPC_W-1:0] OPC_RET   = 4'd5;

    typedef struct packed {
        logic              is_add;
        logic              is_loadi;
        logic              is_jump;
        logic              is_call;
        logic              is_ret;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [IMM_W-1:0]  imm;
    } dec_t;

    // Split a word into fields; unknown opcodes decode to all-zero flags.
    function automatic dec_t decode_word(input logic [INSTR_W-1:0] w);
        dec_t d;
        logic [OPC_W-1:0] op;
        op         = w[INSTR_W-1 -: OPC_W];
        d.is_add   = (op == OPC_ADD);
        d.is_loadi = (op == OPC_LOADI);
        d.is_jump  = (op == OPC_JUMP);
        d.is_call  = (op == OPC_CALL);
        d.is_ret   = (op == OPC_RET);
        d.rd       = w[IMM_W +: RIDX_W];
        d.imm      = w[IMM_W-1:0];
        d.rs       = w[IMM_W-1 -: RIDX_W];
        d.rt       = w[RIDX_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/twostage_fetch.sv
// Fetch stage and execute-stage tracking.
// Holds the fetch counter and the address/valid flag of the word now in
// execute. Assumes the memory returns the word one edge after its address.
// In squash mode, the word fetched while a transfer executes is marked empty.
module twostage_fetch #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              delay_mode,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc_o,
    output logic              ex_valid_o,
    output logic [ADDR_W-1:0] ex_pc_o
);

    logic [ADDR_W-1:0] pc_q;
    logic              ex_valid_q;
    logic [ADDR_W-1:0] ex_pc_q;
    logic [ADDR_W-1:0] pc_next;

    // Choose the next fetch address: transfer target or sequential.
    always_comb begin
        pc_next = redirect ? target : pc_q + ADDR_W'(1);
    end

    // Advance fetch and hand the fetched address to execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= '0;
            ex_valid_q <= 1'b0;
            ex_pc_q    <= '0;
        end else begin
            pc_q       <= pc_next;
            ex_pc_q    <= pc_q;
            ex_valid_q <= !(redirect && !delay_mode);
        end
    end

    assign pc_o       = pc_q;
    assign ex_valid_o = ex_valid_q;
    assign ex_pc_o    = ex_pc_q;

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> pc_q == $past(pc_q) + ADDR_W'(1));

    p_target_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pc_q == $past(target));

    p_squash_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !delay_mode) |=> !ex_valid_q);

    p_slot_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && delay_mode) |=> (ex_valid_q && ex_pc_q == $past(ex_pc_q) + ADDR_W'(1)));

endmodule

// File: rtl/twostage_exec.sv
// Execute stage.
// Decodes the word in execute and produces the register write and any
// transfer. The return address depends on the mode so that, in delay-slot
// mode, the slot is not run again on return. Assumes register reads are
// combinational and writes land at the next edge.
module twostage_exec
    import twostage_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic               ex_valid,
    input  logic [ADDR_W-1:0]  ex_pc,
    input  logic [INSTR_W-1:0] instr,
    input  logic               delay_mode,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic [DATA_W-1:0]  rt_val,
    input  logic [DATA_W-1:0]  link_val,
    output logic [RIDX_W-1:0]  rs_idx,
    output logic [RIDX_W-1:0]  rt_idx,
    output logic               redirect,
    output logic [ADDR_W-1:0]  target,
    output logic               we,
    output logic [RIDX_W-1:0]  waddr,
    output logic [DATA_W-1:0]  wdata
);

    localparam logic [RIDX_W-1:0] LINK_SEL = RIDX_W'(LINK_IDX);

    dec_t              d;
    logic [ADDR_W-1:0] ret_addr;

    // Decode the word in execute.
    always_comb begin
        d = decode_word(instr);
    end

    assign rs_idx = d.rs;
    assign rt_idx = d.rt;

    // Return address: skip the slot in delay-slot mode.
    always_comb begin
        ret_addr = ex_pc + ADDR_W'(delay_mode ? 2 : 1);
    end

    // Produce the transfer request and target.
    always_comb begin
        redirect = ex_valid && (d.is_jump || d.is_call || d.is_ret);
        if (d.is_ret) begin
            target = ADDR_W'(link_val);
        end else begin
            target = ADDR_W'(d.imm);
        end
    end

    // Produce the register write for add, load-immediate and call.
    always_comb begin
        we    = 1'b0;
        waddr = d.rd;
        wdata = '0;
        if (ex_valid) begin
            if (d.is_add) begin
                we    = 1'b1;
                wdata = rs_val + rt_val;
            end else if (d.is_loadi) begin
                we    = 1'b1;
                wdata = DATA_W'(d.imm);
            end else if (d.is_call) begin
                we    = 1'b1;
                waddr = LINK_SEL;
                wdata = DATA_W'(ret_addr);
            end
        end
    end

    always_comb begin
        if (!ex_valid) begin
            p_idle_quiet_r4: assert (!we && !redirect);
        end
        if (ex_valid && (instr[INSTR_W-1 -: OPC_W] == OPC_NOOP ||
                         instr[INSTR_W-1 -: OPC_W] > OPC_RET)) begin
            p_noop_inert_r6: assert (!we && !redirect);
        end
    end

endmodule

// File: rtl/twostage_regfile.sv
// Register file.
// Holds REG_N registers of DATA_W bits, reset to zero, with one write port
// and combinational read ports for the two operands, inspection and the
// link register. Assumes at most one write per cycle.
module twostage_regfile
    import twostage_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RIDX_W-1:0] ra_a,
    output logic [DATA_W-1:0] rd_a,
    input  logic [RIDX_W-1:0] ra_b,
    output logic [DATA_W-1:0] rd_b,
    input  logic [RIDX_W-1:0] ra_dbg,
    output logic [DATA_W-1:0] rd_dbg,
    output logic [DATA_W-1:0] link_o
);

    logic [DATA_W-1:0] regs [REG_N];

    // Clear on reset, otherwise write the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd_a   = regs[ra_a];
    assign rd_b   = regs[ra_b];
    assign rd_dbg = regs[ra_dbg];
    assign link_o = regs[LINK_IDX];

    p_hold_unwritten_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(link_o));

endmodule

// File: rtl/twostage_pipe.sv
// Top: two-stage fetch/execute pipeline.
// Connects fetch, execute and the register file. Every executed word is
// reported on the retire strobe. delay_mode must stay constant while
// out of reset.
module twostage_pipe
    import twostage_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               delay_mode,
    output logic [IMM_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic [RIDX_W-1:0]  rf_raddr,
    output logic [DATA_W-1:0]  rf_rdata,
    output logic               retire_valid,
    output logic [IMM_W-1:0]   retire_pc
);

    localparam int ADDR_W = IMM_W;

    logic              redirect;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] pc;
    logic              ex_valid;
    logic [ADDR_W-1:0] ex_pc;
    logic [RIDX_W-1:0] rs_idx;
    logic [RIDX_W-1:0] rt_idx;
    logic [DATA_W-1:0] rs_val;
    logic [DATA_W-1:0] rt_val;
    logic [DATA_W-1:0] link_val;
    logic              we;
    logic [RIDX_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;

    twostage_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .delay_mode (delay_mode),
        .redirect   (redirect),
        .target     (target),
        .pc_o       (pc),
        .ex_valid_o (ex_valid),
        .ex_pc_o    (ex_pc)
    );

    twostage_exec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
        .ex_valid   (ex_valid),
        .ex_pc      (ex_pc),
        .instr      (imem_rdata),
        .delay_mode (delay_mode),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .link_val   (link_val),
        .rs_idx     (rs_idx),
        .rt_idx     (rt_idx),
        .redirect   (redirect),
        .target     (target),
        .we         (we),
        .waddr      (waddr),
        .wdata      (wdata)
    );

    twostage_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .ra_a   (rs_idx),
        .rd_a   (rs_val),
        .ra_b   (rt_idx),
        .rd_b   (rt_val),
        .ra_dbg (rf_raddr),
        .rd_dbg (rf_rdata),
        .link_o (link_val)
    );

    assign imem_addr    = pc;
    assign retire_valid = ex_valid;
    assign retire_pc    = ex_pc;

    p_call_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && imem_rdata[INSTR_W-1 -: OPC_W] == OPC_CALL)
        |=> ADDR_W'(link_val) == $past(retire_pc) + ADDR_W'(delay_mode ? 2 : 1));

    p_retire_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> $past(imem_addr) == retire_pc);

endmodule

// File: tb/test_twostage_pipe.sv
`timescale 1ns/1ps
module test_twostage_pipe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        delay_mode = 1'b0;
    logic [7:0]  imem_addr;
    logic [15:0] imem_rdata = '0;
    logic [3:0]  rf_raddr = '0;
    logic [7:0]  rf_rdata;
    logic        retire_valid;
    logic [7:0]  retire_pc;

    logic [15:0] mem [256];
    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state.
    int m_pc, m_exv, m_expc;
    int m_regs [16];
    int ret_q [$];
    int exp_q [$];
    int marker_cyc;

    always #2 clk = ~clk;

    always @(posedge clk) imem_rdata <= mem[imem_addr];

    twostage_pipe i_twostage_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .delay_mode   (delay_mode),
        .imem_addr    (imem_addr),
        .imem_rdata   (imem_rdata),
        .rf_raddr     (rf_raddr),
        .rf_rdata     (rf_rdata),
        .retire_valid (retire_valid),
        .retire_pc    (retire_pc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // One model cycle: execute the word in the execute slot, then advance.
    task automatic model_step(input int cyc, input int marker);
        int w, op, rd, imm, redir, tgt;
        redir = 0;
        tgt = 0;
        if (m_exv != 0) begin
            w   = int'(mem[m_expc]);
            op  = (w >> 12) & 15;
            rd  = (w >> 8) & 15;
            imm = w & 255;
            ret_q.push_back(m_expc);
            if (m_expc == marker && marker_cyc < 0) marker_cyc = cyc;
            case (op)
                1: m_regs[rd] = (m_regs[(imm >> 4) & 15] + m_regs[imm & 15]) & 255;
                2: m_regs[rd] = imm;
                3: begin redir = 1; tgt = imm; end
                4: begin
                       m_regs[15] = (m_expc + (delay_mode ? 2 : 1)) & 255;
                       redir = 1;
                       tgt = imm;
                   end
                5: begin redir = 1; tgt = m_regs[15]; end
                default: ;
            endcase
        end
        m_expc = m_pc;
        m_exv  = (redir != 0 && !delay_mode) ? 0 : 1;
        m_pc   = (redir != 0) ? tgt : ((m_pc + 1) & 255);
    endtask

    task automatic run_prog(input bit dm, input int ncyc, input int marker);
        delay_mode = dm;
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_pc = 0; m_exv = 0; m_expc = 0;
        for (int i = 0; i < 16; i++) m_regs[i] = 0;
        ret_q.delete();
        marker_cyc = -1;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            rf_raddr = 4'(cyc % 16);
            #1;
            if (cyc == 0) begin
                chk(imem_addr == 8'd0, "R1 fetch address after reset", imem_addr, 0);
                chk(retire_valid == 1'b0, "R1 no retire after reset", retire_valid, 0);
                chk(rf_rdata == 8'd0, "R1 register cleared", rf_rdata, 0);
            end
            chk(imem_addr == 8'(m_pc), "R2/R3 fetch address", imem_addr, m_pc);
            chk(retire_valid == (m_exv != 0), "R4/R5/R9 retire strobe", retire_valid, m_exv);
            if (m_exv != 0)
                chk(retire_pc == 8'(m_expc), "R9 retire address", retire_pc, m_expc);
            chk(rf_rdata == 8'(m_regs[cyc % 16]), "R7/R11 register read", rf_rdata, m_regs[cyc % 16]);
            model_step(cyc, marker);
            @(negedge clk);
        end
    endtask

    task automatic check_seq(input string req);
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < ret_q.size()) chk(ret_q[i] == exp_q[i], req, ret_q[i], exp_q[i]);
            else chk(0, req, -1, exp_q[i]);
        end
    endtask

    task automatic check_reg(input int idx, input int exp, input string req);
        rf_raddr = 4'(idx);
        #1;
        chk(rf_rdata == 8'(exp), req, rf_rdata, exp);
    endtask

    // Natural ordering: two jumps, each followed by a word that must not run.
    task automatic load_natural();
        clear_mem();
        mem[0]   = 16'h2103;
        mem[1]   = 16'h3064;
        mem[2]   = 16'h23EE;
        mem[100] = 16'h2204;
        mem[101] = 16'h1312;
        mem[102] = 16'h3068;
        mem[103] = 16'h23EE;
        mem[104] = 16'h3068;
        mem[105] = 16'h0000;
    endtask

    // Reordered: work moved into both delay slots.
    task automatic load_reordered();
        clear_mem();
        mem[0]   = 16'h3064;
        mem[1]   = 16'h2103;
        mem[100] = 16'h2204;
        mem[101] = 16'h3068;
        mem[102] = 16'h1312;
        mem[103] = 16'h23EE;
        mem[104] = 16'h3068;
        mem[105] = 16'h0000;
    endtask

    // Call and return, with an undefined opcode at 5.
    task automatic load_call();
        clear_mem();
        mem[0]  = 16'h2101;
        mem[1]  = 16'h4014;
        mem[2]  = 16'h2209;
        mem[3]  = 16'h2333;
        mem[4]  = 16'h3004;
        mem[5]  = 16'hF5AA;
        mem[20] = 16'h1411;
        mem[21] = 16'h5000;
        mem[22] = 16'h2555;
    endtask

    initial begin
        int cyc_flush, cyc_delay;
        clear_mem();

        // R4 R7 R10: natural order in squash mode.
        load_natural();
        run_prog(1'b0, 40, 104);
        cyc_flush = marker_cyc;
        exp_q = '{0, 1, 100, 101, 102, 104};
        check_seq("R4 squash-mode retire order");
        chk(marker_cyc == 8, "R10 squash-mode end cycle", marker_cyc, 8);
        check_reg(1, 3, "R7 r1");
        check_reg(2, 4, "R7 r2");
        check_reg(3, 7, "R4 r3 not overwritten by squashed word");

        // R5 R10: reordered in delay-slot mode.
        load_reordered();
        run_prog(1'b1, 40, 104);
        cyc_delay = marker_cyc;
        exp_q = '{0, 1, 100, 101, 102, 104};
        check_seq("R5 delay-slot retire order");
        chk(marker_cyc == 6, "R10 delay-slot end cycle", marker_cyc, 6);
        chk(cyc_flush - cyc_delay == 2, "R10 cycles saved", cyc_flush - cyc_delay, 2);
        check_reg(1, 3, "R5 r1 from slot");
        check_reg(3, 7, "R10 r3 same result");

        // R4: reordered code in squash mode loses its slot work.
        load_reordered();
        run_prog(1'b0, 30, 104);
        exp_q = '{0, 100, 101, 104};
        check_seq("R4 slots squashed");
        check_reg(1, 0, "R4 r1 untouched");
        check_reg(3, 0, "R4 r3 untouched");

        // R8 R6: call and return in squash mode.
        load_call();
        run_prog(1'b0, 40, 4);
        exp_q = '{0, 1, 20, 21, 2, 3, 4};
        check_seq("R8 squash-mode call order");
        chk(marker_cyc == 9, "R8 squash-mode end cycle", marker_cyc, 9);
        check_reg(15, 2, "R8 link is call+1");
        check_reg(4, 2, "R7 add r4");
        check_reg(5, 0, "R4 r5 untouched");

        // R8 R6 R5: call and return in delay-slot mode.
        load_call();
        run_prog(1'b1, 40, 4);
        exp_q = '{0, 1, 2, 20, 21, 22, 3, 4, 5, 4};
        check_seq("R8 delay-slot call order");
        chk(marker_cyc == 8, "R8 delay-slot end cycle", marker_cyc, 8);
        check_reg(15, 3, "R8 link is call+2");
        check_reg(2, 9, "R5 r2 once from slot");
        check_reg(5, 8'h55, "R5 r5 from return slot");
        check_reg(3, 8'h33, "R8 r3 after return");
        check_reg(10, 0, "R6 undefined opcode writes nothing");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule